// File: doc/BRIEF.md
# SHA-1 Four-Round Choose Update Unit

This block advances a SHA-1 compression state through four consecutive rounds that use the choose (bitwise select) function. The caller supplies three operands. The first is a 128-bit packed word holding four 32-bit working variables. The second is a separate 32-bit fifth variable. The third is a 128-bit vector of four schedule words, each already summed with its round constant. The unit returns the updated 128-bit packed state. The fifth variable produced by the last round is dropped.

The unit accepts operands on a one-cycle `start` while idle and runs one round per clock for four clocks, holding `busy` high during that time. It then raises `done` for one cycle and holds the result on `state_out` until the next operation finishes. Both the cycle count and the timing are the same for every operand value, so the unit can be used where data-independent timing is required. A `start` that arrives while the unit is busy is ignored.

Top module: `sha1c_unit`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `done` are 0 and `state_out` is all zeros.
- R2: When `start` is sampled high while `busy` is 0, the operands are captured and `busy` is 1 for exactly four cycles that follow that edge.
- R3: `done` goes high in the cycle that follows the fourth round edge, which is four edges after the start edge. It stays high for exactly one cycle and is never high together with `busy`.
- R4: The rounds consume `sched_in` lowest word first: round k uses `sched_in[32k+31:32k]` for k = 0..3.
- R5: Each round forms a choose value bit by bit. It selects the bit of variable 3 (`[95:64]`) where variable 2 (`[63:32]`) is 1, and the bit of variable 4 (`[127:96]`) where variable 2 is 0.
- R6: Each round computes a new sum. The sum is the fifth variable, plus variable 1 (`[31:0]`) rotated left by 5, plus the choose value, plus the round's schedule word. All additions are modulo 2^32.
- R7: After each round the variables shift. The new variable 1 is the sum. The new variable 2 is the old variable 1. The new variable 3 is the old variable 2 rotated left by 30. The new variable 4 is the old variable 3. The new fifth variable is the old variable 4. `state_out` packs variables 4..1 from high bits to low bits, and the final fifth variable is not output.
- R8: A `start` that arrives while `busy` is 1 has no effect: the result and the timing of the running operation are unchanged, and no extra `done` follows.
- R9: `state_out` changes only in the cycle where `done` rises and is otherwise stable.
- R10: The latency from start to `done` is the same for every operand value.
- R11: A `start` in the cycle where `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; honoured only while idle |
| state_in | input | 128 | Packed working variables 4..1, variable 1 in the low bits |
| e_in | input | 32 | Fifth working variable |
| sched_in | input | 32*LANES | Schedule-plus-constant words, round 0 in the low bits |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle completion pulse |
| state_out | output | 128 | Updated packed state, held until the next completion |

## Verification
The bench builds the unit with the default `LANES = 4`, which is the only setting that gives the four-round update. Single-bit operands whose results were derived by hand pin down the word order, the rotation amounts and the variable shift. A model written with the usual a..e naming and the XOR form of the choose function covers the all-ones (carry wrap-around) case and varied random-looking operands. Timed starts placed mid-run and in the `done` cycle exercise the ignore rule and back-to-back operation.

// File: rtl/sha1c_pkg.sv
package sha1c_pkg;
  localparam int WORD_W      = 32;
  localparam int STATE_WORDS = 4;
  localparam int STATE_W     = WORD_W * STATE_WORDS;

  typedef logic [WORD_W-1:0] word_t;

  // Packed working state; field v1 occupies the low 32 bits.
  typedef struct packed {
    word_t v4;
    word_t v3;
    word_t v2;
    word_t v1;
  } state_t;

  function automatic word_t rotl(input word_t v, input int unsigned amt);
    return (v << amt) | (v >> (WORD_W - amt));
  endfunction

  function automatic word_t choose(input word_t sel, input word_t if_one, input word_t if_zero);
    return (sel & if_one) | (~sel & if_zero);
  endfunction

  function automatic word_t round_sum(input word_t fifth, input word_t v1,
                                      input word_t ch, input word_t wk);
    return fifth + rotl(v1, 5) + ch + wk;
  endfunction
endpackage

// File: rtl/sha1c_round.sv
module sha1c_round
  import sha1c_pkg::*;
(
  input  state_t x_cur,
  input  word_t  y_cur,
  input  word_t  w_cur,
  output state_t x_nxt,
  output word_t  y_nxt,
  output word_t  ch_val
);
  word_t sum_val;

  always_comb begin
    ch_val  = choose(x_cur.v2, x_cur.v3, x_cur.v4);
    sum_val = round_sum(y_cur, x_cur.v1, ch_val, w_cur);
    // 160-bit image {sum, v4, v3, rot30(v2), v1} rotated left by one word
    y_nxt    = x_cur.v4;
    x_nxt.v4 = x_cur.v3;
    x_nxt.v3 = rotl(x_cur.v2, 30);
    x_nxt.v2 = x_cur.v1;
    x_nxt.v1 = sum_val;
  end
endmodule

// File: rtl/sha1c_word_pick.sv
module sha1c_word_pick
  import sha1c_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*WORD_W-1:0] vec,
  input  logic [IDX_W-1:0]        idx,
  output word_t                   word
);
  word_t lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = vec[g*WORD_W +: WORD_W];
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < LANES; i++) begin
      if (idx == IDX_W'(i)) word = lane[i];
    end
  end
endmodule

// File: rtl/sha1c_ctrl.sv
module sha1c_ctrl #(
  parameter int ROUNDS = 4,
  localparam int IDX_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             accept,
  output logic             step,
  output logic             last,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic             done_q;

  assign accept = start && !busy_q;
  assign step   = busy_q;
  assign last   = busy_q && (idx_q == IDX_W'(ROUNDS - 1));
  assign idx    = idx_q;
  assign busy   = busy_q;
  assign done   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else if (busy_q) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_run_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx != IDX_W'(ROUNDS - 1)) |=> busy);
  assert_fixed_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == IDX_W'(ROUNDS - 1)) |=> (done && !busy));
  assert_accept_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && idx == '0));
endmodule

// File: rtl/sha1c_datapath.sv
module sha1c_datapath
  import sha1c_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic                    last,
  input  logic [IDX_W-1:0]        idx,
  input  logic [STATE_W-1:0]      state_in,
  input  word_t                   e_in,
  input  logic [LANES*WORD_W-1:0] sched_in,
  output logic [STATE_W-1:0]      result
);
  state_t                  x_q;
  word_t                   y_q;
  logic [LANES*WORD_W-1:0] sched_q;
  logic [STATE_W-1:0]      result_q;
  word_t                   w_cur;
  state_t                  x_nxt;
  word_t                   y_nxt;
  word_t                   ch_val;

  sha1c_word_pick #(.LANES(LANES)) u_pick (
    .vec  (sched_q),
    .idx  (idx),
    .word (w_cur)
  );

  sha1c_round u_round (
    .x_cur  (x_q),
    .y_cur  (y_q),
    .w_cur  (w_cur),
    .x_nxt  (x_nxt),
    .y_nxt  (y_nxt),
    .ch_val (ch_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q      <= '0;
      y_q      <= '0;
      sched_q  <= '0;
      result_q <= '0;
    end else if (load) begin
      x_q     <= state_t'(state_in);
      y_q     <= e_in;
      sched_q <= sched_in;
    end else if (step) begin
      x_q <= x_nxt;
      y_q <= y_nxt;
      if (last) result_q <= x_nxt;
    end
  end

  assign result = result_q;

  assert_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (x_q.v2 == $past(x_q.v1) && x_q.v4 == $past(x_q.v3)));
  assert_fifth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (y_q == $past(x_q.v4)));
  assert_rot30_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (x_q.v3 == {$past(x_q.v2[1:0]), $past(x_q.v2[31:2])}));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(result));
  assert_choose_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> ((ch_val & ~x_q.v2) == (x_q.v4 & ~x_q.v2)));
endmodule

// File: rtl/sha1c_unit.sv
module sha1c_unit
  import sha1c_pkg::*;
#(
  parameter int LANES = 4,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [STATE_W-1:0]      state_in,
  input  logic [WORD_W-1:0]       e_in,
  input  logic [LANES*WORD_W-1:0] sched_in,
  output logic                    busy,
  output logic                    done,
  output logic [STATE_W-1:0]      state_out
);
  logic             accept;
  logic             step;
  logic             last;
  logic [IDX_W-1:0] idx;

  sha1c_ctrl #(.ROUNDS(LANES)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .step   (step),
    .last   (last),
    .idx    (idx),
    .busy   (busy),
    .done   (done)
  );

  sha1c_datapath #(.LANES(LANES)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (step),
    .last     (last),
    .idx      (idx),
    .state_in (state_in),
    .e_in     (e_in),
    .sched_in (sched_in),
    .result   (state_out)
  );

  assert_out_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(state_out)));
endmodule

// File: tb/sha1c_unit_test.sv
module sha1c_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] state_in = '0;
  logic [31:0]  e_in = '0;
  logic [127:0] sched_in = '0;
  logic         busy;
  logic         done;
  logic [127:0] state_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sha1c_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .state_in(state_in),
    .e_in(e_in), .sched_in(sched_in), .busy(busy), .done(done),
    .state_out(state_out)
  );

  function automatic logic [127:0] model(input logic [127:0] s,
                                         input logic [31:0] e0,
                                         input logic [127:0] w);
    logic [31:0] a, b, c, d, e, f, tmp;
    a = s[31:0]; b = s[63:32]; c = s[95:64]; d = s[127:96]; e = e0;
    for (int k = 0; k < 4; k++) begin
      f   = ((c ^ d) & b) ^ d;
      tmp = {a[26:0], a[31:27]} + f + e + w[32*k +: 32];
      e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = tmp;
    end
    return {d, c, b, a};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation; returns cycles to done and the result.
  task automatic run_op(input logic [127:0] s, input logic [31:0] e, input logic [127:0] w,
                        output int lat, output logic [127:0] res);
    @(negedge clk);
    state_in = s; e_in = e; sched_in = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    res = state_out;
  endtask

  task automatic t_reset;
    check("R1 busy", {127'd0, busy}, 128'd0);
    check("R1 done", {127'd0, done}, 128'd0);
    check("R1 out", state_out, 128'd0);
  endtask

  task automatic t_hand;
    int lat; logic [127:0] r;
    run_op('0, 32'd0, '0, lat, r);
    check("R6 zero", r, 128'd0);
    run_op('0, 32'd1, '0, lat, r);
    check("R6 R7 fifth", r, {32'h40000000, 32'h8, 32'h400, 32'h8000});
    run_op('0, 32'd0, {96'd0, 32'd1}, lat, r);
    check("R4 word0", r, {32'h40000000, 32'h8, 32'h400, 32'h8000});
    run_op('0, 32'd0, {32'd1, 96'd0}, lat, r);
    check("R4 word3", r, 128'd1);
  endtask

  task automatic t_choose;
    int lat; logic [127:0] r, s;
    s = {32'h55555555, 32'hAAAAAAAA, 32'hFFFF0000, 32'h0};
    run_op(s, 32'd0, '0, lat, r);
    check("R5 select", r, model(s, 32'd0, '0));
  endtask

  task automatic t_wrap;
    int lat; logic [127:0] r;
    run_op({128{1'b1}}, 32'hFFFFFFFF, {128{1'b1}}, lat, r);
    check("R6 modulo", r, model({128{1'b1}}, 32'hFFFFFFFF, {128{1'b1}}));
  endtask

  task automatic t_latency;
    int lat; logic [127:0] r, s, w;
    logic [31:0] e;
    for (int i = 0; i < 5; i++) begin
      s = {32'h67452301 * (i + 3), 32'hEFCDAB89 ^ i, 32'h98BADCFE + i, 32'h10325476 * (i + 1)};
      w = {32'h5A827999 + i, 32'hC3D2E1F0 * i, 32'h01234567 ^ (i << 7), 32'hDEADBEEF + i};
      e = 32'hC3D2E1F0 + i * 32'h11111111;
      run_op(s, e, w, lat, r);
      check("R7 packing", r, model(s, e, w));
      check("R10 latency", 128'(lat), 128'd4);
    end
  endtask

  task automatic t_busy_ignored;
    int lat; logic [127:0] s, w;
    s = 128'h0123456789ABCDEF_FEDCBA9876543210;
    w = 128'h11223344_55667788_99AABBCC_DDEEFF00;
    @(negedge clk);
    state_in = s; e_in = 32'h13579BDF; sched_in = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy set", {127'd0, busy}, 128'd1);
    @(negedge clk);
    state_in = ~s; e_in = 32'h0; sched_in = ~w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 2;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R8 timing", 128'(lat), 128'd4);
    check("R8 result", state_out, model(s, 32'h13579BDF, w));
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (done) check("R8 no extra done", 128'd1, 128'd0);
    end
    check("R9 held", state_out, model(s, 32'h13579BDF, w));
    check("R2 idle", {127'd0, busy}, 128'd0);
  endtask

  task automatic t_back_to_back;
    int lat; logic [127:0] r, s2, w2;
    s2 = 128'hCAFEBABE_0BADF00D_12345678_9ABCDEF0;
    w2 = 128'h0F0F0F0F_F0F0F0F0_33333333_CCCCCCCC;
    run_op(128'h1, 32'h2, 128'h3, lat, r);
    state_in = s2; e_in = 32'h600DF00D; sched_in = w2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 accepted", {127'd0, busy}, 128'd1);
    check("R3 one cycle", {127'd0, done}, 128'd0);
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R11 latency", 128'(lat), 128'd4);
    check("R11 result", state_out, model(s2, 32'h600DF00D, w2));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hand();
    t_choose();
    t_wrap();
    t_latency();
    t_busy_ignored();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule